// File: doc/BRIEF.md
# Periodic Countdown Timer with Watchdog Escalation

This block is a shared 29-bit down-counter. It advances only on a slow tick enable, normally one pulse per microsecond. Software loads a start value together with a mode bit and an enable bit. The counter then runs down and expires once the start value plus one ticks have passed. In periodic mode it reloads and runs again. In one-shot mode it stops and clears its own enable. Every expiry raises an interrupt flag. The flag stays raised until software has done two things since that expiry, in either order: written a one to the clear bit of the status register, and read the trigger register.

The same timer serves as a system watchdog. Once the watchdog is armed, a reset request pulse is issued only when an expiry happens while the interrupt from the previous expiry is still unacknowledged. This is the second unserviced expiry. A single missed interrupt is tolerated. Writing zero to the trigger register stops the counter and drops any pending interrupt. Writing zero to the status register disarms the watchdog.

Register map, one address bit. Address 0 is the trigger register:
- write: bits 28:0 start value, bit 30 periodic mode (1 = reload, 0 = one-shot), bit 31 enable;
- read: the same fields, with the live enable, and bit 29 reads zero.

Address 1 is the status register:
- write: bit 31 watchdog arm, bit 30 interrupt clear (write one);
- read: bit 31 arm, bit 30 interrupt pending, bit 29 zero, bits 28:0 live count.

Top module: `tick_wdog_timer`

## Requirements
- R1: After reset the interrupt and reset-request outputs are low and both registers read as zero.
- R2: A trigger write loads the count from bits 28:0. The count then drops by one only on cycles where the tick input is high, and holds otherwise. It is visible in status bits 28:0.
- R3: With start value V the first expiry happens on the (V+1)-th tick after the load. In periodic mode the count reloads V at expiry, so each later period is also V+1 ticks. V=0 expires on every tick.
- R4: The interrupt output rises in the cycle after the tick that causes an expiry.
- R5: A pending interrupt clears one cycle after the later of two acknowledge conditions: a status write with bit 30 set, and a trigger read. The conditions may come in either order. Either one alone leaves it pending. Conditions met while nothing is pending are not remembered.
- R6: In one-shot mode (bit 30 = 0) an expiry clears the enable bit, which then reads 0 in trigger bit 31. The count stays at zero and no further expiry occurs.
- R7: With the watchdog armed (status bit 31 written 1), no reset request is issued at an expiry that finds no interrupt pending. A reset request is issued in the cycle after an expiry that finds the interrupt still pending.
- R8: The reset request is a pulse one clock cycle long.
- R9: A trigger write with bit 31 = 0 stops the counter and clears the pending interrupt, which is low from the next cycle. A status write with bit 31 = 0 disarms the watchdog, and later expiries with the interrupt pending then issue no reset request.
- R10: Read data appears on the read-data port in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one pulse per timer tick |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register select: 0 trigger, 1 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt pending |
| wdog_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
Every result is due exactly one cycle after the stimulus edge that causes it:
- the interrupt and the reset request follow the expiring tick;
- the interrupt's fall follows the completing acknowledge;
- read data follows the read strobe;
- the reset request is low again in the next cycle.

The bench's driver stamps each expected value with the cycle index it is due in, counting the single register stage between inputs and outputs. The monitor compares that value at the falling edge of exactly that cycle. Values that are not met in their cycle, or that are left over when the run ends, count as failures.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic {
        TW_REG_TRIG = 1'b0,
        TW_REG_STAT = 1'b1
    } tw_reg_e;

    typedef struct packed {
        logic trig_wr;
        logic stat_wr;
        logic trig_rd;
        logic stat_rd;
    } tw_bus_ev_t;

endpackage

// File: rtl/tw_counter.sv
module tw_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             load_en_i,
    input  logic             load_per_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             en_o,
    output logic             per_o,
    output logic             expire_o
);

    typedef struct packed {
        logic             en;
        logic             per;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (load_i) begin
            st_d.en     = load_en_i;
            st_d.per    = load_per_i;
            st_d.reload = load_val_i;
            st_d.cnt    = load_val_i;
        end else if (tick_i && st_q.en) begin
            if (st_q.cnt == '0) begin
                expire_d = 1'b1;
                if (st_q.per) begin
                    st_d.cnt = st_q.reload;
                end else begin
                    st_d.en = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign reload_o = st_q.reload;
    assign en_o     = st_q.en;
    assign per_o    = st_q.per;
    assign expire_o = expire_d;

endmodule

// File: rtl/tw_ack_track.sv
module tw_ack_track (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_req_i,
    input  logic trig_rd_i,
    input  logic stop_i,
    output logic pend_o
);

    typedef struct packed {
        logic pend;
        logic clr_seen;
        logic rd_seen;
    } ack_state_t;

    ack_state_t st_d, st_q;
    logic       clr_now, rd_now;

    always_comb begin
        st_d    = st_q;
        clr_now = st_q.clr_seen | clr_req_i;
        rd_now  = st_q.rd_seen | trig_rd_i;
        if (stop_i) begin
            st_d = '0;
        end else if (expire_i) begin
            // a fresh expiry restarts the acknowledge handshake
            st_d.pend     = 1'b1;
            st_d.clr_seen = 1'b0;
            st_d.rd_seen  = 1'b0;
        end else if (st_q.pend) begin
            if (clr_now && rd_now) begin
                st_d = '0;
            end else begin
                st_d.clr_seen = clr_now;
                st_d.rd_seen  = rd_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/tw_escalate.sv
module tw_escalate (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_wr_i,
    input  logic arm_val_i,
    input  logic expire_i,
    input  logic pend_i,
    output logic arm_o,
    output logic rst_req_o
);

    typedef struct packed {
        logic arm;
        logic rst_req;
    } esc_state_t;

    esc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_wr_i) begin
            st_d.arm = arm_val_i;
        end
        // second unserviced expiry: pending flag from the previous one still set
        st_d.rst_req = expire_i && pend_i && st_q.arm && !st_q.rst_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arm_o     = st_q.arm;
    assign rst_req_o = st_q.rst_req;

endmodule

// File: rtl/tick_wdog_timer.sv
module tick_wdog_timer #(
    parameter int CNT_W  = 29,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              wdog_rst_o
);

    import tw_pkg::*;

    localparam int EN_BIT  = DATA_W - 1;
    localparam int PER_BIT = DATA_W - 2;
    localparam int ARM_BIT = DATA_W - 1;
    localparam int CLR_BIT = DATA_W - 2;
    localparam int PAD_W   = DATA_W - CNT_W - 2;

    tw_bus_ev_t       ev;
    logic [CNT_W-1:0] cnt_w, reload_w;
    logic             en_w, per_w, expire_w, pend_w, arm_w, rst_w, stop_w;
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic [PAD_W-1:0] unused_rsvd;

    always_comb begin
        ev.trig_wr = wr_en_i && (addr_i == TW_REG_TRIG);
        ev.stat_wr = wr_en_i && (addr_i == TW_REG_STAT);
        ev.trig_rd = rd_en_i && (addr_i == TW_REG_TRIG);
        ev.stat_rd = rd_en_i && (addr_i == TW_REG_STAT);
    end

    assign stop_w      = ev.trig_wr && !wdata_i[EN_BIT];
    assign unused_rsvd = wdata_i[CNT_W +: PAD_W];

    tw_counter #(.CNT_W(CNT_W)) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (ev.trig_wr),
        .load_val_i (wdata_i[CNT_W-1:0]),
        .load_en_i  (wdata_i[EN_BIT]),
        .load_per_i (wdata_i[PER_BIT]),
        .cnt_o      (cnt_w),
        .reload_o   (reload_w),
        .en_o       (en_w),
        .per_o      (per_w),
        .expire_o   (expire_w)
    );

    tw_ack_track i_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_i  (expire_w),
        .clr_req_i (ev.stat_wr && wdata_i[CLR_BIT]),
        .trig_rd_i (ev.trig_rd),
        .stop_i    (stop_w),
        .pend_o    (pend_w)
    );

    tw_escalate i_esc (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_wr_i  (ev.stat_wr),
        .arm_val_i (wdata_i[ARM_BIT]),
        .expire_i  (expire_w),
        .pend_i    (pend_w),
        .arm_o     (arm_w),
        .rst_req_o (rst_w)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (ev.trig_rd) begin
            rdata_d = {en_w, per_w, {PAD_W{1'b0}}, reload_w};
        end else if (ev.stat_rd) begin
            rdata_d = {arm_w, pend_w, {PAD_W{1'b0}}, cnt_w};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o    = rdata_q;
    assign irq_o      = pend_w;
    assign wdog_rst_o = rst_w;

endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
    parameter int CNT_W  = 29,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic              addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              irq_o,
    input logic              wdog_rst_o,
    input logic              expire,
    input logic [CNT_W-1:0]  cnt
);

    // R4: an expiry raises the interrupt in the next cycle
    a_r4_expiry_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq_o);

    // R8: reset request never lasts two cycles
    a_r8_rst_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_o |=> !wdog_rst_o);

    // R7: a reset request only follows a cycle with the interrupt pending
    a_r7_rst_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_o |-> $past(irq_o));

    // R9: a trigger write with enable low drops the interrupt
    a_r9_stop_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && !wdata_i[DATA_W-1]) |=> !irq_o);

    // R2: without a tick or a load the count holds
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(wr_en_i && !addr_i)) |=> $stable(cnt));

endmodule

bind tick_wdog_timer tw_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_tw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .irq_o      (irq_o),
    .wdog_rst_o (wdog_rst_o),
    .expire     (expire_w),
    .cnt        (cnt_w)
);

// File: tb/test_tick_wdog_timer.sv
`timescale 1ns/1ps
module test_tick_wdog_timer;

    localparam int SIG_IRQ = 0;
    localparam int SIG_RST = 1;
    localparam int SIG_RD  = 2;

    typedef struct {
        int          cyc;
        int          sig;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic        addr_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;
    logic        wdog_rst_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];
    exp_t item;
    logic [31:0] act;

    tick_wdog_timer i_tick_wdog_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .irq_o      (irq_o),
        .wdog_rst_o (wdog_rst_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare each expected item in the cycle it is due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item = sb.pop_front();
            case (item.sig)
                SIG_IRQ: act = {31'b0, irq_o};
                SIG_RST: act = {31'b0, wdog_rst_o};
                default: act = rdata_o;
            endcase
            checks++;
            if (item.cyc != cyc || act !== item.val) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h (cycle %0d due %0d)",
                         item.tag, act, item.val, cyc, item.cyc);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push(int dly, int sig, logic [31:0] v, string tag);
        exp_t e;
        e.cyc = cyc + dly;
        e.sig = sig;
        e.val = v;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic bus_write(logic a, logic [31:0] d);
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        step();
        wr_en_i = 1'b0;
        wdata_i = '0;
    endtask

    task automatic bus_read(logic a, logic [31:0] expv, string tag);
        rd_en_i = 1'b1;
        addr_i  = a;
        push(1, SIG_RD, expv, tag);
        step();
        rd_en_i = 1'b0;
    endtask

    task automatic tickn(int n, logic irq_e, logic rst_e, string tag);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            push(1, SIG_IRQ, {31'b0, irq_e}, tag);
            push(1, SIG_RST, {31'b0, rst_e}, tag);
            step();
            tick_i = 1'b0;
        end
    endtask

    task automatic hold_check(logic irq_e, logic rst_e, string tag);
        push(1, SIG_IRQ, {31'b0, irq_e}, tag);
        push(1, SIG_RST, {31'b0, rst_e}, tag);
        step();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        // R1: reset state
        hold_check(1'b0, 1'b0, "R1 reset outputs");
        bus_read(1'b0, 32'h0, "R1 trigger reads zero");
        bus_read(1'b1, 32'h0, "R1 status reads zero");

        // R2/R10: load periodic V=3
        bus_write(1'b0, 32'hC000_0003);
        bus_read(1'b0, 32'hC000_0003, "R10 trigger readback");
        bus_read(1'b1, 32'h0000_0003, "R2 loaded count");
        bus_read(1'b1, 32'h0000_0003, "R2 count holds without tick");
        tickn(1, 1'b0, 1'b0, "R2 first tick");
        bus_read(1'b1, 32'h0000_0002, "R2 count after one tick");
        tickn(2, 1'b0, 1'b0, "R3 no expiry before V+1 ticks");
        tickn(1, 1'b1, 1'b0, "R4 irq one cycle after expiring tick");
        bus_read(1'b1, 32'h4000_0003, "R3 periodic reload and pending");

        // R5: clear then read
        bus_write(1'b1, 32'h4000_0000);
        hold_check(1'b1, 1'b0, "R5 clear bit alone keeps irq");
        bus_read(1'b0, 32'hC000_0003, "R5 trigger read value");
        hold_check(1'b0, 1'b0, "R5 irq cleared after both conditions");

        // R5: read then clear
        tickn(3, 1'b0, 1'b0, "R3 second period");
        tickn(1, 1'b1, 1'b0, "R3 second expiry");
        bus_read(1'b0, 32'hC000_0003, "R5 read first");
        hold_check(1'b1, 1'b0, "R5 trigger read alone keeps irq");
        bus_write(1'b1, 32'h4000_0000);
        hold_check(1'b0, 1'b0, "R5 irq cleared in reverse order");

        // R5: acknowledges while idle are not remembered
        bus_write(1'b1, 32'h4000_0000);
        bus_read(1'b0, 32'hC000_0003, "R5 idle read");
        tickn(3, 1'b0, 1'b0, "R3 third period");
        tickn(1, 1'b1, 1'b0, "R4 third expiry");
        bus_write(1'b1, 32'h4000_0000);
        hold_check(1'b1, 1'b0, "R5 stale acknowledge ignored");
        bus_read(1'b0, 32'hC000_0003, "R5 completing read");
        hold_check(1'b0, 1'b0, "R5 cleared");

        // R7/R8: armed watchdog
        bus_write(1'b1, 32'h8000_0000);
        tickn(3, 1'b0, 1'b0, "R7 armed period");
        tickn(1, 1'b1, 1'b0, "R7 first miss gives no reset");
        tickn(3, 1'b1, 1'b0, "R7 pending period");
        tickn(1, 1'b1, 1'b1, "R7 second miss gives reset");
        hold_check(1'b1, 1'b0, "R8 reset is one cycle");

        // R9: stop and disarm
        bus_write(1'b0, 32'h0000_0000);
        hold_check(1'b0, 1'b0, "R9 stop clears irq");
        tickn(5, 1'b0, 1'b0, "R9 stopped counter silent");
        bus_read(1'b1, 32'h8000_0000, "R9 stopped status");
        bus_write(1'b1, 32'h0000_0000);
        bus_read(1'b1, 32'h0000_0000, "R9 disarmed status");
        bus_write(1'b0, 32'hC000_0001);
        tickn(1, 1'b0, 1'b0, "R9 disarmed period");
        tickn(1, 1'b1, 1'b0, "R9 disarmed first expiry");
        tickn(1, 1'b1, 1'b0, "R9 disarmed period two");
        tickn(1, 1'b1, 1'b0, "R9 disarmed second miss no reset");
        bus_write(1'b0, 32'h0000_0000);

        // R3: V=0 expires every tick
        bus_write(1'b0, 32'hC000_0000);
        tickn(1, 1'b1, 1'b0, "R3 zero value expires on first tick");
        bus_write(1'b0, 32'h0000_0000);
        hold_check(1'b0, 1'b0, "R9 stop after zero value");

        // R6: one-shot
        bus_write(1'b0, 32'h8000_0002);
        tickn(2, 1'b0, 1'b0, "R6 one-shot counting");
        tickn(1, 1'b1, 1'b0, "R6 one-shot expiry");
        bus_read(1'b0, 32'h0000_0002, "R6 enable cleared");
        bus_read(1'b1, 32'h4000_0000, "R6 count stays zero");
        bus_write(1'b1, 32'h4000_0000);
        bus_read(1'b0, 32'h0000_0002, "R6 ack read");
        hold_check(1'b0, 1'b0, "R6 acknowledged");
        tickn(5, 1'b0, 1'b0, "R6 no further expiry");

        repeat (3) step();
        if (sb.size() != 0) begin
            errors += sb.size();
            checks += sb.size();
            $display("FAIL scoreboard: actual=%0d left expected=0", sb.size());
        end
        finish_run();
    end

endmodule